// File: doc/BRIEF.md
# Relocatable SRAM Access Controller

This block wraps a 4 KB on-chip SRAM so that software can place it anywhere in a 24-bit address map and so that every access to it is screened. A bus master issues one-cycle requests carrying an address, a read/write flag, a byte/word size flag, and two attribute bits: supervisor/user and program/data. The controller compares the upper address bits with a programmable base field. It checks the attributes against a 2-bit permitted-space code. It then either performs the transfer or refuses it.

A small register window at a fixed address holds three registers. The control word carries a halt (low-power) bit, a sticky base lock, the space code and a standby-power status bit. Two base words hold the array's placement. The base can only be moved while the array is halted and unlocked. The array leaves reset halted at base zero, so it takes no part in decoding until software places it and clears halt.

Top module: `reloc_sram`

## Requirements
- R1: After reset the control word reads 0x9000 (halt set, power status set, lock clear, space 00). Both base words read 0, and an access at an address whose bits 23:12 are 0 gets neither acknowledge nor error.
- R2: The register window sits at REG_BASE. Word offsets are: 0 for the control word, 2 for the high base word (address bits 23:16 in data bits 7:0), and 4 for the low base word (address bits 15:12 in data bits 15:12). Any access to these offsets is acknowledged. Writes take effect only with the supervisor attribute set; user-mode writes are acknowledged and change nothing. Offset 6 is not acknowledged.
- R3: While halt (control bit 15) is 1, array reads and writes get no acknowledge and no error, and the array contents do not change.
- R4: A base word write changes the base only while halt is 1 and lock is 0. In every other state the write is acknowledged and ignored.
- R5: Lock (control bit 11), once written to 1, stays 1 until reset. Writing 0 has no effect on it.
- R6: With halt at 0, an access hits the array exactly when address bits 23:12 equal the base field. The array is aligned to 4 KB. Addresses outside the window get neither acknowledge nor error.
- R7: The space code (control bits 9:8) admits accesses as follows. 00 admits all. 01 admits program accesses in either mode. 10 admits supervisor accesses of either type. 11 admits supervisor program accesses only.
- R8: An array access refused by the space code gets no acknowledge and an error pulse in the response cycle, and it leaves the array unchanged.
- R9: A byte write touches one lane only: address bit 0 = 0 selects data bits 15:8, and 1 selects bits 7:0. Word accesses ignore address bit 0.
- R10: Power status (control bit 12) reads 1 after reset. It falls to 0 in the cycle after the power-lost input is seen high and stays 0 until reset.
- R11: Control bits 14:13, 10 and 7:0, high-base bits 15:8 and low-base bits 11:0 read 0 and ignore writes.
- R12: Acknowledge, error and read data appear exactly one clock after the request cycle. No response occurs without a request in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Request valid for this cycle |
| addr_i | input | 24 | Byte address |
| wr_i | input | 1 | 1 = write, 0 = read |
| byte_i | input | 1 | 1 = byte transfer, 0 = word transfer |
| wdata_i | input | 16 | Write data |
| super_i | input | 1 | 1 = supervisor, 0 = user |
| prog_i | input | 1 | 1 = program access, 0 = data access |
| pwr_lost_i | input | 1 | Array standby power has failed |
| ack_o | output | 1 | Transfer acknowledged |
| err_o | output | 1 | Access refused by space code |
| rdata_o | output | 16 | Read data, valid with ack_o |

## Verification
The bench tries to move the base while the array runs and after the lock is set. A design that gates the base write on the wrong state would relocate the live array, and the array would then answer at a new address. It sweeps all four space codes against all four attribute pairs. It follows a refused write with a read-back, which catches a decoder that swaps the privilege and type bits or that still writes on refusal. It also probes the addresses just outside the window, writes single byte lanes, writes to the array while halted, and tries to clear the lock and the power status. A design that mishandled any of these would acknowledge a foreign address, corrupt the neighbouring byte, or let software undo a one-way bit.

// File: rtl/reloc_sram_pkg.sv
package reloc_sram_pkg;
  // register word index inside the window (address bits 2:1)
  localparam logic [1:0] IDX_CTL  = 2'd0;
  localparam logic [1:0] IDX_BHI  = 2'd1;
  localparam logic [1:0] IDX_BLO  = 2'd2;

  // control word bit positions
  localparam int B_HALT = 15;
  localparam int B_PWR  = 12;
  localparam int B_LOCK = 11;
  localparam int B_SPC  = 8;

  // permitted-space rule: bit1 demands supervisor, bit0 demands program
  function automatic logic space_ok(input logic [1:0] spc, input logic sup, input logic prg);
    return (!spc[1] || sup) && (!spc[0] || prg);
  endfunction
endpackage

// File: rtl/reloc_sram_dec.sv
module reloc_sram_dec
  import reloc_sram_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          ARR_LG2  = 12,
  parameter logic [23:0] REG_BASE = 24'hFFE000,
  localparam int         BASE_W   = ADDR_W - ARR_LG2
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_sz,
  input  logic              sup,
  input  logic              prg,
  input  logic              halt,
  input  logic [1:0]        spc,
  input  logic [BASE_W-1:0] base,
  output logic              reg_acc,
  output logic [1:0]        reg_idx,
  output logic              arr_go,
  output logic              arr_deny,
  output logic [1:0]        lanes
);
  logic win_hit;
  logic arr_hit;

  always_comb begin
    win_hit  = (addr[ADDR_W-1:3] == REG_BASE[ADDR_W-1:3]);
    reg_idx  = addr[2:1];
    reg_acc  = req && win_hit && (reg_idx != 2'd3);
    arr_hit  = !win_hit && !halt && (addr[ADDR_W-1:ARR_LG2] == base);
    arr_go   = req && arr_hit && space_ok(spc, sup, prg);
    arr_deny = req && arr_hit && !space_ok(spc, sup, prg);
    // lane 1 = bits 15:8 at even address
    lanes    = byte_sz ? (addr[0] ? 2'b01 : 2'b10) : 2'b11;
  end
endmodule

// File: rtl/reloc_sram_regs.sv
module reloc_sram_regs
  import reloc_sram_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int ARR_LG2 = 12,
  parameter bit HAS_MON = 1'b1,
  localparam int BASE_W = ADDR_W - ARR_LG2,
  localparam int HI_W   = ADDR_W - 16,
  localparam int LO_W   = 16 - ARR_LG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        idx,
  input  logic [1:0]        lanes,
  input  logic [15:0]       wdata,
  input  logic              pwr_lost,
  output logic              halt,
  output logic              lock,
  output logic [1:0]        spc,
  output logic              pwr_ok,
  output logic [BASE_W-1:0] base,
  output logic [15:0]       rd_word
);
  logic [HI_W-1:0] hi_q, hi_n;
  logic [LO_W-1:0] lo_q, lo_n;
  logic            halt_n, lock_n;
  logic [1:0]      spc_n;
  logic            ctl_we, base_we;
  logic [15:0]     bmask;
  logic            unused_wd;

  assign unused_wd = ^{wdata[14:13], wdata[10], wdata[ARR_LG2-1:HI_W]};

  always_comb begin
    bmask   = {{8{lanes[1]}}, {8{lanes[0]}}};
    ctl_we  = we && (idx == IDX_CTL) && lanes[1];
    base_we = we && halt && !lock;
    halt_n  = wdata[B_HALT];
    lock_n  = lock || wdata[B_LOCK];
    spc_n   = wdata[B_SPC+1:B_SPC];
    hi_n    = (hi_q & ~bmask[HI_W-1:0]) | (wdata[HI_W-1:0] & bmask[HI_W-1:0]);
    lo_n    = (lo_q & ~bmask[15:ARR_LG2]) | (wdata[15:ARR_LG2] & bmask[15:ARR_LG2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt <= 1'b1;
      lock <= 1'b0;
      spc  <= 2'b00;
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (ctl_we) begin
        halt <= halt_n;
        lock <= lock_n;
        spc  <= spc_n;
      end
      if (base_we && idx == IDX_BHI) hi_q <= hi_n;
      if (base_we && idx == IDX_BLO) lo_q <= lo_n;
    end
  end

  generate
    if (HAS_MON) begin : g_mon
      logic pwr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pwr_q <= 1'b1;
        else if (pwr_lost) pwr_q <= 1'b0;
      end
      assign pwr_ok = pwr_q;
    end else begin : g_nomon
      logic unused_pwr;
      assign unused_pwr = pwr_lost;
      assign pwr_ok     = 1'b0;
    end
  endgenerate

  assign base = {hi_q, lo_q};

  always_comb begin
    rd_word = '0;
    case (idx)
      IDX_CTL: begin
        rd_word[B_HALT]         = halt;
        rd_word[B_PWR]          = pwr_ok;
        rd_word[B_LOCK]         = lock;
        rd_word[B_SPC+1:B_SPC]  = spc;
      end
      IDX_BHI: rd_word[HI_W-1:0]    = hi_q;
      IDX_BLO: rd_word[15:ARR_LG2]  = lo_q;
      default: rd_word = '0;
    endcase
  end
endmodule

// File: rtl/reloc_sram_arr.sv
module reloc_sram_arr #(
  parameter int ARR_LG2 = 12,
  localparam int IDX_W  = ARR_LG2 - 1,
  localparam int WORDS  = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [1:0]       lanes,
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] store [WORDS];
    logic [7:0] rd_q;
    always_ff @(posedge clk) begin
      if (en && we && lanes[g]) store[idx] <= wdata[g*8 +: 8];
      if (en && !we)            rd_q       <= store[idx];
    end
    assign rdata[g*8 +: 8] = rd_q;
  end
endmodule

// File: rtl/reloc_sram.sv
module reloc_sram
  import reloc_sram_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          ARR_LG2  = 12,
  parameter logic [23:0] REG_BASE = 24'hFFE000,
  parameter bit          HAS_MON  = 1'b1,
  localparam int         BASE_W   = ADDR_W - ARR_LG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              byte_i,
  input  logic [15:0]       wdata_i,
  input  logic              super_i,
  input  logic              prog_i,
  input  logic              pwr_lost_i,
  output logic              ack_o,
  output logic              err_o,
  output logic [15:0]       rdata_o
);
  logic              rst_meta, rst_sync_n;
  logic              reg_acc, arr_go, arr_deny;
  logic [1:0]        reg_idx, lanes;
  logic              halt, lock, pwr_ok;
  logic [1:0]        spc;
  logic [BASE_W-1:0] base;
  logic [15:0]       reg_word, arr_word;
  logic              ack_n, err_n, rsel_n;
  logic              rsel_q;
  logic [15:0]       reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  reloc_sram_dec #(.ADDR_W(ADDR_W), .ARR_LG2(ARR_LG2), .REG_BASE(REG_BASE)) u_dec (
    .req(req_i), .addr(addr_i), .byte_sz(byte_i), .sup(super_i), .prg(prog_i),
    .halt(halt), .spc(spc), .base(base),
    .reg_acc(reg_acc), .reg_idx(reg_idx), .arr_go(arr_go), .arr_deny(arr_deny),
    .lanes(lanes)
  );

  reloc_sram_regs #(.ADDR_W(ADDR_W), .ARR_LG2(ARR_LG2), .HAS_MON(HAS_MON)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .we(reg_acc && wr_i && super_i), .idx(reg_idx), .lanes(lanes), .wdata(wdata_i),
    .pwr_lost(pwr_lost_i),
    .halt(halt), .lock(lock), .spc(spc), .pwr_ok(pwr_ok), .base(base),
    .rd_word(reg_word)
  );

  reloc_sram_arr #(.ARR_LG2(ARR_LG2)) u_arr (
    .clk(clk), .en(arr_go), .we(wr_i), .lanes(lanes),
    .idx(addr_i[ARR_LG2-1:1]), .wdata(wdata_i), .rdata(arr_word)
  );

  always_comb begin
    ack_n  = reg_acc || arr_go;
    err_n  = arr_deny;
    rsel_n = reg_acc;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ack_o  <= 1'b0;
      err_o  <= 1'b0;
      rsel_q <= 1'b0;
      reg_q  <= '0;
    end else begin
      ack_o  <= ack_n;
      err_o  <= err_n;
      rsel_q <= rsel_n;
      if (reg_acc) reg_q <= reg_word;
    end
  end

  assign rdata_o = rsel_q ? reg_q : arr_word;
endmodule

// File: rtl/reloc_sram_chk.sv
module reloc_sram_chk #(
  parameter int          ADDR_W   = 24,
  parameter int          ARR_LG2  = 12,
  parameter logic [23:0] REG_BASE = 24'hFFE000,
  parameter bit          HAS_MON  = 1'b1,
  localparam int         BASE_W   = ADDR_W - ARR_LG2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              pwr_lost_i,
  input logic              ack_o,
  input logic              err_o,
  input logic              halt,
  input logic              lock,
  input logic              pwr_ok,
  input logic [BASE_W-1:0] base
);
  // R8: a refused access is never also acknowledged
  p_ack_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && err_o));

  // R12: every response follows a request one cycle earlier
  p_resp_needs_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o || err_o) |-> $past(req_i));

  // R3: halted array access draws no response
  p_halt_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && halt && addr_i[ADDR_W-1:3] != REG_BASE[ADDR_W-1:3]
     && addr_i[ADDR_W-1:ARR_LG2] == base) |=> (!ack_o && !err_o));

  // R5: lock is one-way
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);

  // R4: base frozen while running or locked
  p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt || lock) |=> $stable(base));

  if (HAS_MON) begin : g_mon_chk
    // R10: power status latches low
    p_pwr_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok |=> !pwr_ok);
    p_pwr_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_lost_i |=> !pwr_ok);
  end
endmodule

bind reloc_sram reloc_sram_chk #(
  .ADDR_W(ADDR_W), .ARR_LG2(ARR_LG2), .REG_BASE(REG_BASE), .HAS_MON(HAS_MON)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_i(req_i), .addr_i(addr_i),
  .pwr_lost_i(pwr_lost_i), .ack_o(ack_o), .err_o(err_o),
  .halt(halt), .lock(lock), .pwr_ok(pwr_ok), .base(base)
);

// File: tb/reloc_sram_bench.sv
module reloc_sram_bench;
  localparam int          CLK_PERIOD = 10;
  localparam logic [23:0] RB         = 24'hFFE000;
  localparam logic [23:0] AB         = 24'h123000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, wr_i, byte_i, super_i, prog_i, pwr_lost_i;
  logic [23:0] addr_i;
  logic [15:0] wdata_i;
  logic        ack_o, err_o;
  logic [15:0] rdata_o;

  int checks = 0;
  int errors = 0;

  logic        r_ack, r_err;
  logic [15:0] r_dat;

  always #(CLK_PERIOD/2) clk = ~clk;

  reloc_sram u_reloc_sram (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .wr_i(wr_i),
    .byte_i(byte_i), .wdata_i(wdata_i), .super_i(super_i), .prog_i(prog_i),
    .pwr_lost_i(pwr_lost_i), .ack_o(ack_o), .err_o(err_o), .rdata_o(rdata_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; response sampled after the next rising edge
  task automatic acc(input logic [23:0] a, input logic w, input logic b,
                     input logic [15:0] d, input logic s, input logic p);
    @(negedge clk);
    req_i = 1'b1; addr_i = a; wr_i = w; byte_i = b; wdata_i = d; super_i = s; prog_i = p;
    @(negedge clk);
    r_ack = ack_o; r_err = err_o; r_dat = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic sw(input logic [23:0] a, input logic [15:0] d);
    acc(a, 1'b1, 1'b0, d, 1'b1, 1'b0);
  endtask

  task automatic sr(input logic [23:0] a);
    acc(a, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
  endtask

  task automatic t_reset;
    sr(RB);     check("R1 ctl reset", r_dat, 16'h9000);
    check("R12 reg ack", r_ack, 1'b1);
    sr(RB + 2); check("R1 bhi reset", r_dat, 16'h0000);
    sr(RB + 4); check("R1 blo reset", r_dat, 16'h0000);
    sr(24'h000010); check("R1 halted base0 silent", {r_ack, r_err}, 2'b00);
    sr(RB + 6); check("R2 offset 6 no ack", r_ack, 1'b0);
  endtask

  task automatic t_place;
    sw(RB + 2, 16'hAB12); sr(RB + 2); check("R11 bhi upper zero", r_dat, 16'h0012);
    sw(RB + 4, 16'h3FFF); sr(RB + 4); check("R11 blo lower zero", r_dat, 16'h3000);
    sw(RB, 16'h0000); sr(RB); check("R2 ctl run", r_dat, 16'h1000);
  endtask

  task automatic t_array;
    sw(AB + 4, 16'hBEEF); check("R6 write ack", r_ack, 1'b1);
    sr(AB + 4); check("R12 read data", r_dat, 16'hBEEF);
    sw(AB + 6, 16'h5555);
    sw(RB, 16'h8000);
    sw(AB + 6, 16'h1111); check("R3 halted write silent", {r_ack, r_err}, 2'b00);
    sr(AB + 6); check("R3 halted read silent", {r_ack, r_err}, 2'b00);
    sw(RB, 16'h0000);
    sr(AB + 6); check("R3 contents kept", r_dat, 16'h5555);
    sw(RB + 2, 16'h0044); check("R4 running base write acked", r_ack, 1'b1);
    sr(RB + 2); check("R4 base kept while running", r_dat, 16'h0012);
    sr(AB + 4); check("R4 array still placed", r_dat, 16'hBEEF);
  endtask

  task automatic t_decode;
    sr(24'h124000); check("R6 above window", {r_ack, r_err}, 2'b00);
    sr(24'h122FFE); check("R6 below window", {r_ack, r_err}, 2'b00);
    sw(AB + 12'hFFE, 16'h7E57); sr(AB + 12'hFFE);
    check("R6 top word", {r_ack, r_dat}, {1'b1, 16'h7E57});
    sr(AB + 5); check("R9 word ignores a0", r_dat, 16'hBEEF);
  endtask

  task automatic t_bytes;
    sw(AB + 16, 16'hA1B2);
    acc(AB + 16, 1'b1, 1'b1, 16'hCC00, 1'b1, 1'b0);
    sr(AB + 16); check("R9 upper lane", r_dat, 16'hCCB2);
    acc(AB + 17, 1'b1, 1'b1, 16'h00DD, 1'b1, 1'b0);
    sr(AB + 16); check("R9 lower lane", r_dat, 16'hCCDD);
  endtask

  task automatic t_space;
    for (int c = 0; c < 4; c++) begin
      sw(RB, 16'(c << 8));
      for (int k = 0; k < 4; k++) begin
        logic s, p, ok;
        s  = k[1]; p = k[0];
        ok = (!c[1] || s) && (!c[0] || p);
        acc(AB + 4, 1'b0, 1'b0, 16'h0, s, p);
        check($sformatf("R7 code %0d attr %0d ack", c, k), r_ack, ok);
        check($sformatf("R8 code %0d attr %0d err", c, k), r_err, !ok);
      end
    end
    acc(AB + 4, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0);
    check("R8 denied write err", {r_ack, r_err}, 2'b01);
    sw(RB, 16'h0000);
    sr(AB + 4); check("R8 denied write no effect", r_dat, 16'hBEEF);
  endtask

  task automatic t_user_reg;
    acc(RB, 1'b1, 1'b0, 16'h8000, 1'b0, 1'b0);
    check("R2 user write acked", r_ack, 1'b1);
    acc(RB, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
    check("R2 user write ignored", r_dat, 16'h1000);
  endtask

  task automatic t_lock;
    sw(RB, 16'h8800);
    sw(RB + 2, 16'h0077); sr(RB + 2); check("R4 locked base kept", r_dat, 16'h0012);
    sw(RB, 16'h8000); sr(RB); check("R5 lock sticky", r_dat, 16'h9800);
  endtask

  task automatic t_power;
    @(negedge clk); pwr_lost_i = 1'b1;
    @(negedge clk); pwr_lost_i = 1'b0;
    sr(RB); check("R10 status cleared", r_dat, 16'h8800);
    repeat (3) @(negedge clk);
    sr(RB); check("R10 status stays low", r_dat, 16'h8800);
  endtask

  task automatic t_reserved;
    sw(RB, 16'hFFFF); sr(RB); check("R11 ctl reserved", r_dat, 16'h8B00);
  endtask

  initial begin
    req_i = 0; addr_i = 0; wr_i = 0; byte_i = 0; wdata_i = 0;
    super_i = 0; prog_i = 0; pwr_lost_i = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_place;
    t_array;
    t_decode;
    t_bytes;
    t_space;
    t_user_reg;
    t_lock;
    t_power;
    t_reserved;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule